// File: doc/BRIEF.md
# Monitor Descriptor Ring Producer

This block fills a circular ring of fixed-size descriptor entries kept in on-chip memory. An upstream source hands over one entry at a time through a valid/ready handshake. The entry is made of seven complete 32-bit words plus the low half of an eighth word. The block then writes all eight words to memory on consecutive cycles and moves its head index forward by one entry.

Before the eighth word goes to memory, the block fills in three things in that word: a fixed ring tag, a 4-bit pass stamp, and zeros in a reserved nibble. The pass stamp lets a consumer find fresh entries by polling their contents. It does not need to read the head index. Stale memory holds a stamp of 0. Entries from the first pass through the ring carry 1. Each later pass carries the next value, modulo 16. As a result the stamp's least significant bit flips every time the ring wraps.

The consumer drives its tail index into the block. The block stops taking entries while advancing the head would make it equal to the tail.

Top module: `mon_ring_producer`

## Requirements
- R1: After reset, `head_idx` is 0, `mem_we` is 0, and `in_ready` is 1 provided `tail_idx` is not 1.
- R2: An accepted entry is written during the 8 cycles that follow the accept cycle, one word per cycle. Word k goes to address `{head_idx, k[2:0]}` in order k = 0..7, and words 0..6 carry the input words unchanged.
- R3: Bits 27:20 of every written word 7 equal the `RING_TAG` parameter.
- R4: Bits 19:16 of every written word 7 are 0, and bits 15:0 equal the `in_top_low` value captured at accept.
- R5: Entries written during the first pass through the ring (before the head index first wraps) carry a pass stamp of 1 in bits 31:28 of word 7.
- R6: The pass stamp increases by one each time the head index wraps from DEPTH-1 to 0. After 15 it continues at 0, so its LSB toggles on every wrap.
- R7: `head_idx` changes only in the cycle after word 7 is written. It then steps by one and wraps from DEPTH-1 to 0.
- R8: While (`head_idx` + 1) mod DEPTH equals `tail_idx`, `in_ready` is 0 and no memory write starts.
- R9: `in_ready` is 0 in every cycle in which `mem_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Entry can be taken this cycle |
| in_words | input | 224 | Words 0..6, word k at bits [32k+31:32k] |
| in_top_low | input | 16 | Bits 15:0 of word 7 |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | IDX_W+3 | Word address: entry index and word number |
| mem_wdata | output | 32 | Memory write data |
| head_idx | output | IDX_W | Next entry slot to be written |
| tail_idx | input | IDX_W | Consumer's read position |

## Verification
The bench runs the ring through more than sixteen full passes. This exercises the stamp going from 1 up through 15, rolling over to 0, and returning to 1.
- A design that stamped the internal pass count without the +1 offset would write 0 on the first pass, so new entries would look stale.
- A design that let the counter saturate would stop toggling the LSB after the fifteenth wrap.

The full condition is tested by holding the tail at 0 and offering an entry while the head sits one slot behind it. A design with an off-by-one full compare would overwrite the unread slot, and the scoreboard sees that write as unexpected.

The head index is checked both during the word 7 write and after it. This catches a head that moves early, which would misaddress the tail of the entry.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 8;
  localparam int SEL_W   = $clog2(N_WORDS);
  localparam int STAMP_W = 4;
  localparam int TAG_W   = 8;
  localparam int LOW_W   = 16;

  // Successor of a ring slot, wrapping at depth-1.
  function automatic int slot_after(int cur, int depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction

  // Assemble the top word: stamp | tag | reserved zeros | caller bits.
  function automatic logic [WORD_W-1:0] build_top_word(
      logic [LOW_W-1:0] low, logic [TAG_W-1:0] tag, logic [STAMP_W-1:0] stamp);
    return {stamp, tag, 4'b0000, low};
  endfunction
endpackage

// File: rtl/mrp_index_tracker.sv
module mrp_index_tracker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic [CNT_W-1:0] passes,
  output logic             full,
  output logic             wrap
);
  logic [IDX_W-1:0] head_nxt;

  assign head_nxt = IDX_W'(mrp_pkg::slot_after(int'(head), DEPTH));
  assign full     = (head_nxt == tail);
  assign wrap     = step && (head == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      passes <= '0;
    end else if (step) begin
      head <= head_nxt;
      if (wrap) passes <= passes + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mrp_entry_serializer.sv
module mrp_entry_serializer #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8,
  parameter int SEL_W   = $clog2(N_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [N_WORDS*WORD_W-1:0] entry,
  output logic                      busy,
  output logic [SEL_W-1:0]          wsel,
  output logic [WORD_W-1:0]         wdata,
  output logic                      last
);
  logic [N_WORDS-1:0][WORD_W-1:0] hold_q;

  assign wdata = hold_q[wsel];
  assign last  = busy && (wsel == SEL_W'(N_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wsel   <= '0;
      hold_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      wsel   <= '0;
      hold_q <= entry;
    end else if (busy) begin
      wsel <= wsel + SEL_W'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_ring_producer.sv
module mon_ring_producer #(
  parameter int         DEPTH    = 8,
  parameter logic [7:0] RING_TAG = 8'h5A,
  localparam int        IDX_W    = $clog2(DEPTH),
  localparam int        BODY_W   = (mrp_pkg::N_WORDS - 1) * mrp_pkg::WORD_W,
  localparam int        ADDR_W   = IDX_W + mrp_pkg::SEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BODY_W-1:0]         in_words,
  input  logic [mrp_pkg::LOW_W-1:0] in_top_low,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [mrp_pkg::WORD_W-1:0] mem_wdata,
  output logic [IDX_W-1:0]          head_idx,
  input  logic [IDX_W-1:0]          tail_idx
);
  import mrp_pkg::*;

  logic               accept;
  logic               entry_done;
  logic               wrap_evt;
  logic               ring_full;
  logic               busy;
  logic [SEL_W-1:0]   word_sel;
  logic [STAMP_W-1:0] passes;
  logic [STAMP_W-1:0] stamp;
  logic [WORD_W-1:0]  top_word;

  assign in_ready = !busy && !ring_full;
  assign accept   = in_valid && in_ready;
  assign stamp    = passes + STAMP_W'(1);
  assign top_word = build_top_word(in_top_low, RING_TAG, stamp);

  mrp_index_tracker #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(STAMP_W)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (entry_done),
    .tail  (tail_idx),
    .head  (head_idx),
    .passes(passes),
    .full  (ring_full),
    .wrap  (wrap_evt)
  );

  mrp_entry_serializer #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .SEL_W(SEL_W)) u_ser (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .entry({top_word, in_words}),
    .busy (busy),
    .wsel (word_sel),
    .wdata(mem_wdata),
    .last (entry_done)
  );

  assign mem_we   = busy;
  assign mem_addr = {head_idx, word_sel};
endmodule

// File: rtl/mrp_checker.sv
module mrp_checker #(
  parameter int         DEPTH    = 8,
  parameter logic [7:0] RING_TAG = 8'h5A,
  localparam int        IDX_W    = $clog2(DEPTH),
  localparam int        ADDR_W   = IDX_W + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              accept,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [IDX_W-1:0]  head_idx,
  input logic [IDX_W-1:0]  tail_idx,
  input logic              entry_done,
  input logic              wrap_evt
);
  logic [IDX_W-1:0] head_succ;
  assign head_succ = IDX_W'(mrp_pkg::slot_after(int'(head_idx), DEPTH));

  // R2
  word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[2:0] != 3'd7) |=>
      (mem_we && mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1));

  // R2
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_we && mem_addr[2:0] == 3'd0));

  // R3
  ring_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[2:0] == 3'd7) |-> (mem_wdata[27:20] == RING_TAG));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[2:0] == 3'd7) |-> (mem_wdata[19:16] == 4'd0));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_done |=> $stable(head_idx));

  // R7
  head_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (head_idx == '0));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_succ == tail_idx) |-> !in_ready);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_ready);
endmodule

bind mon_ring_producer mrp_checker #(.DEPTH(DEPTH), .RING_TAG(RING_TAG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .accept    (accept),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .head_idx  (head_idx),
  .tail_idx  (tail_idx),
  .entry_done(entry_done),
  .wrap_evt  (wrap_evt)
);

// File: tb/mon_ring_producer_tb.sv
module mon_ring_producer_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         DEPTH      = 8;
  localparam int         IDX_W      = $clog2(DEPTH);
  localparam logic [7:0] TAG        = 8'hC3;
  localparam int         WD_CYCLES  = 50000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [223:0]     in_words = '0;
  logic [15:0]      in_top_low = '0;
  logic             mem_we;
  logic [IDX_W+2:0] mem_addr;
  logic [31:0]      mem_wdata;
  logic [IDX_W-1:0] head_idx;
  logic [IDX_W-1:0] tail_idx = '0;

  int n_chk = 0;
  int n_bad = 0;
  int m_head = 0;
  int m_pass = 0;
  logic [IDX_W+2:0] q_addr[$];
  logic [31:0]      q_data[$];
  int               q_pass[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_ring_producer #(.DEPTH(DEPTH), .RING_TAG(TAG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_words(in_words), .in_top_low(in_top_low), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .head_idx(head_idx),
    .tail_idx(tail_idx)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compare every memory write against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R8 unexpected write", 32'(mem_addr), 32'hFFFF_FFFF);
      end else begin
        logic [IDX_W+2:0] ea;
        logic [31:0] ed;
        int ep;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        ep = q_pass.pop_front();
        check(mem_addr == ea, "R2 address", 32'(mem_addr), 32'(ea));
        if (ea[2:0] != 3'd7) begin
          check(mem_wdata == ed, "R2 word data", mem_wdata, ed);
        end else begin
          check(mem_wdata[27:20] == ed[27:20], "R3 ring tag", 32'(mem_wdata[27:20]), 32'(ed[27:20]));
          check(mem_wdata[19:0] == ed[19:0], "R4 reserved/low bits", 32'(mem_wdata[19:0]), 32'(ed[19:0]));
          check(mem_wdata[31:28] == ed[31:28], (ep == 0) ? "R5 first-pass stamp" : "R6 pass stamp",
                32'(mem_wdata[31:28]), 32'(ed[31:28]));
          check(head_idx == ea[IDX_W+2:3], "R7 head held during word 7", 32'(head_idx), 32'(ea[IDX_W+2:3]));
        end
      end
    end
  end

  task automatic push(input logic [31:0] seed, input bit free_tail);
    logic [31:0] w [8];
    logic [3:0]  st;
    if (free_tail) tail_idx = IDX_W'(m_head);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      w[k] = seed * 32'(k + 3) + 32'h1357_9BDF * 32'(k);
      in_words[k*32 +: 32] = w[k];
    end
    in_top_low = seed[15:0] ^ 16'hA5A5;
    st = 4'((m_pass + 1) % 16);
    w[7] = {st, TAG, 4'h0, in_top_low};
    for (int k = 0; k < 8; k++) begin
      q_addr.push_back({IDX_W'(m_head), 3'(k)});
      q_data.push_back(w[k]);
      q_pass.push_back(m_pass);
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (q_addr.size() != 0) @(negedge clk);
    @(negedge clk);
    m_head = (m_head + 1) % DEPTH;
    if (m_head == 0) m_pass = m_pass + 1;
    check(head_idx == IDX_W'(m_head), "R7 head after entry", 32'(head_idx), 32'(m_head));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(head_idx == '0, "R1 reset head", 32'(head_idx), 0);
    check(mem_we == 1'b0, "R1 reset write strobe", 32'(mem_we), 0);
    check(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 1);

    // Fill with tail pinned at 0 until one slot short of full (R8).
    for (int i = 0; i < DEPTH - 1; i++) push(32'h1000 + 32'(i), 1'b0);
    @(negedge clk);
    check(in_ready == 1'b0, "R8 ready low when full", 32'(in_ready), 0);
    in_valid = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check(in_ready == 1'b0 && mem_we == 1'b0, "R8 stall while full",
            {30'd0, in_ready, mem_we}, 0);
    end
    in_valid = 1'b0;
    check(head_idx == IDX_W'(DEPTH - 1), "R8 head held while full", 32'(head_idx), DEPTH - 1);

    // R9: ready stays low during an entry write.
    tail_idx = IDX_W'(3);
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready after tail moves", 32'(in_ready), 1);

    // Long run over seventeen passes: stamp climbs, rolls to 0, back to 1 (R6).
    for (int i = 0; i < 17 * DEPTH + 2; i++) begin
      push(32'hBEEF_0000 ^ (32'(i) * 32'h0001_0203), 1'b1);
      if (i == 0) check(in_ready == 1'b1, "R9 ready after entry", 32'(in_ready), 1);
    end
    in_valid = 1'b1;
    tail_idx = IDX_W'(m_head);
    in_words = '1;
    in_top_low = 16'h0F0F;
    for (int k = 0; k < 8; k++) begin
      q_addr.push_back({IDX_W'(m_head), 3'(k)});
      q_data.push_back(k == 7 ? {4'((m_pass + 1) % 16), TAG, 4'h0, 16'h0F0F} : 32'hFFFF_FFFF);
      q_pass.push_back(m_pass);
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 8; c++) begin
      check(in_ready == 1'b0, "R9 ready low while writing", 32'(in_ready), 0);
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(q_addr.size() == 0, "R2 all words written", 32'(q_addr.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule